// File: doc/BRIEF.md
# Dual-Channel Prescaled Timestamp Counter

This block keeps two independent timestamp counts for keeping audio and video streams aligned. Both channels run from one fixed reference clock. Each channel has its own prescaler. The prescaler counts reference cycles up to a programmable limit, and on each wrap the channel's 33-bit count advances by one. Software can pause either channel, load a new start value into either count, and rewrite the divisor at any moment, all without stopping the other channel.

Software reaches the block through a plain register port: a write strobe, an address, write data and combinational read data. Words are 32 bits wide. A count is seen through this port as its upper 32 bits. On a load, hardware forces the count's bit 0 to zero. The two divisor fields share one register. A field value of zero is reserved, and the block runs it as one.

Top module: `tsc_timestamp_pair`

## Requirements
- R1: After reset, the divisor register (address 1) reads 0x05DB05DB. The control register (address 0) and both count words (addresses 2 and 3) read 0.
- R2: A write to address 2 (channel 0) or address 3 (channel 1) loads that count with {wdata, 1'b0}. A read of that address returns count bits [32:1].
- R3: With divisor field d (d > 0), a running channel's count rises by exactly one every d+1 reference cycles.
- R4: A load also clears that channel's prescaler. The first increment after a load lands d+1 cycles after the load edge.
- R5: While a channel's pause bit is 1, its count and its prescaler both hold. After resume, the period that was interrupted completes only with its remaining cycles.
- R6: Channel 0 takes its divisor from bits [11:0] and its pause from control bit 0. Channel 1 takes its divisor from bits [27:16] and its pause from control bit 1. Neither channel's settings or loads affect the other.
- R7: A divisor write takes effect on the next cycle without clearing the prescaler. If the prescaler already holds a value at or above the new field, the count increments on the next cycle.
- R8: A divisor field of zero behaves as a field of one, giving a period of two cycles.
- R9: The count wraps modulo 2^33. From 0x1_FFFF_FFFF the next increment gives 0.
- R10: The control register reads back its pause bits in [1:0]. Divisor bits outside the two fields read 0. Addresses 4 to 7 read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |

## Verification
The bench builds the block with its default parameters: two channels, 12-bit prescalers, 33-bit counts and the reset divisor 0x05DB05DB. It programs divisor fields of 0, 1, 2, 3 and 7, so whole prescaler periods fit into a few cycles and edge-exact sampling can tell a d-cycle period from a (d+1)-cycle one. Loading 0xFFFFFFFF puts the count two increments below the carry out of bit 32, which brings the wrap into reach. Because a read shows only bits [32:1], every timing check watches for the second increment after a known phase.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
  localparam int PRE_W  = 12;
  localparam int WORD_W = 32;
  localparam int CNT_W  = WORD_W + 1;

  typedef logic [PRE_W-1:0]  pre_t;
  typedef logic [WORD_W-1:0] word_t;
  typedef logic [CNT_W-1:0]  cnt_t;

  // compare limit for a divisor field; the reserved value 0 runs as 1
  function automatic pre_t eff_limit(pre_t field);
    return (field == '0) ? pre_t'(1) : field;
  endfunction

  // start value placed in a count from a software word
  function automatic cnt_t load_value(word_t w);
    return {w, 1'b0};
  endfunction
endpackage

// File: rtl/tsc_prescaler.sv
module tsc_prescaler
  import tsc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic pause,
  input  pre_t div_field,
  output logic tick
);
  pre_t pre_q;
  pre_t limit;
  logic reached;

  always_comb begin
    limit   = eff_limit(div_field);
    reached = (pre_q >= limit);
    tick    = !load && !pause && reached;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pre_q <= '0;
    else if (load)   pre_q <= '0;
    else if (pause)  pre_q <= pre_q;
    else if (reached) pre_q <= '0;
    else             pre_q <= pre_q + pre_t'(1);
  end

  AST_PRE_LOAD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (pre_q == '0)); // R4
  AST_PRE_PAUSE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (pause && !load) |=> $stable(pre_q)); // R5
  AST_PRE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (pre_q == '0)); // R3
endmodule

// File: rtl/tsc_count.sv
module tsc_count
  import tsc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  word_t load_word,
  input  logic  tick,
  output cnt_t  cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (load)  cnt <= load_value(load_word);
    else if (tick)  cnt <= cnt + cnt_t'(1);
  end

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load) |=> (cnt == $past(cnt) + cnt_t'(1))); // R3
  AST_CNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load) |=> $stable(cnt)); // R5
  AST_CNT_LOAD_LSB: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt[0] == 1'b0)); // R2
endmodule

// File: rtl/tsc_regs.sv
module tsc_regs
  import tsc_pkg::*;
#(
  parameter int          NCH          = 2,
  parameter int          ADDR_W       = 3,
  parameter int          FIELD_STRIDE = 16,
  parameter logic [31:0] DIV_RESET    = 32'h05DB05DB
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  word_t             wdata,
  input  word_t             cnt_hi [NCH],
  output logic [NCH-1:0]    pause,
  output pre_t              div_f  [NCH],
  output logic [NCH-1:0]    load,
  output word_t             load_word,
  output word_t             rdata
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_DIV  = ADDR_W'(1);
  localparam int                A_CNT0 = 2;

  logic wr_ctrl, wr_div;

  always_comb begin
    wr_ctrl   = wr_en && (addr == A_CTRL);
    wr_div    = wr_en && (addr == A_DIV);
    load_word = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pause <= '0;
    else if (wr_ctrl) pause <= wdata[NCH-1:0];
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      div_f[i] <= DIV_RESET[FIELD_STRIDE*i +: PRE_W];
      else if (wr_div) div_f[i] <= wdata[FIELD_STRIDE*i +: PRE_W];
    end
    assign load[i] = wr_en && (addr == ADDR_W'(A_CNT0 + i));
  end

  always_comb begin
    rdata = '0;
    if (addr == A_CTRL) begin
      rdata[NCH-1:0] = pause;
    end else if (addr == A_DIV) begin
      for (int i = 0; i < NCH; i++) rdata[FIELD_STRIDE*i +: PRE_W] = div_f[i];
    end else begin
      for (int i = 0; i < NCH; i++)
        if (addr == ADDR_W'(A_CNT0 + i)) rdata = cnt_hi[i];
    end
  end

  AST_LOAD_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(load)); // R6
  AST_CTRL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> (pause == $past(wdata[NCH-1:0]))); // R10
endmodule

// File: rtl/tsc_timestamp_pair.sv
module tsc_timestamp_pair
  import tsc_pkg::*;
#(
  parameter int          NCH          = 2,
  parameter int          ADDR_W       = 3,
  parameter int          FIELD_STRIDE = 16,
  parameter logic [31:0] DIV_RESET    = 32'h05DB05DB
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata
);
  logic [NCH-1:0] pause, load, tick;
  pre_t           div_f  [NCH];
  word_t          cnt_hi [NCH];
  word_t          load_word;

  tsc_regs #(
    .NCH(NCH), .ADDR_W(ADDR_W), .FIELD_STRIDE(FIELD_STRIDE), .DIV_RESET(DIV_RESET)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .cnt_hi(cnt_hi), .pause(pause), .div_f(div_f), .load(load),
    .load_word(load_word), .rdata(rdata)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_chan
    cnt_t cnt;

    tsc_prescaler u_pre (
      .clk(clk), .rst_n(rst_n), .load(load[i]), .pause(pause[i]),
      .div_field(div_f[i]), .tick(tick[i])
    );

    tsc_count u_cnt (
      .clk(clk), .rst_n(rst_n), .load(load[i]), .load_word(load_word),
      .tick(tick[i]), .cnt(cnt)
    );

    assign cnt_hi[i] = cnt[CNT_W-1:1];

    AST_PAUSED_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      pause[i] |-> !tick[i]); // R5
  end
endmodule

// File: tb/tsc_timestamp_pair_tb.sv
module tsc_timestamp_pair_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;

  tsc_timestamp_pair u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got=0x%08h expected=0x%08h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic edges(input int n);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(3'd1, v); chk("R1 divisor reset", v, 32'h05DB05DB);
    rd(3'd0, v); chk("R1 control reset", v, 32'h0);
    rd(3'd2, v); chk("R1 count0 reset", v, 32'h0);
    rd(3'd3, v); chk("R1 count1 reset", v, 32'h0);
  endtask

  task automatic t_load_readback;
    logic [31:0] v;
    wr(3'd3, 32'h12345678);
    rd(3'd3, v); chk("R2 load ch1 readback", v, 32'h12345678);
    wr(3'd2, 32'hCAFEF00D);
    rd(3'd2, v); chk("R2 load ch0 readback", v, 32'hCAFEF00D);
  endtask

  task automatic t_reg_access;
    logic [31:0] v;
    wr(3'd0, 32'hFFFF_FFFF);
    rd(3'd0, v); chk("R10 control readback", v, 32'h3);
    wr(3'd0, 32'h0);
    wr(3'd1, 32'hFFFF_FFFF);
    rd(3'd1, v); chk("R10 divisor masked", v, 32'h0FFF0FFF);
    rd(3'd5, v); chk("R10 unmapped reads zero", v, 32'h0);
    wr(3'd1, 32'h05DB05DB);
  endtask

  // d=3 -> period 4; bits [32:1] change on the 2nd increment, edge 8 after load
  task automatic t_period;
    logic [31:0] v;
    wr(3'd0, 32'h0);
    wr(3'd1, 32'h05DB0003);
    wr(3'd2, 32'd10);
    edges(7); rd(3'd2, v); chk("R4 no early step after load", v, 32'd10);
    edges(1); rd(3'd2, v); chk("R3 two periods of d+1", v, 32'd11);
    edges(8); rd(3'd2, v); chk("R3 steady period", v, 32'd12);
  endtask

  task automatic t_pause;
    logic [31:0] v;
    wr(3'd1, 32'h05DB0003);
    wr(3'd2, 32'd0);
    edges(2);
    wr(3'd0, 32'h1);         // prescaler reaches 3 on this edge, then holds
    edges(20); rd(3'd2, v); chk("R5 paused count holds", v, 32'd0);
    wr(3'd0, 32'h0);
    edges(4); rd(3'd2, v); chk("R5 resume keeps phase (before)", v, 32'd0);
    edges(1); rd(3'd2, v); chk("R5 resume keeps phase (step)", v, 32'd1);
  endtask

  task automatic t_on_the_fly;
    logic [31:0] v;
    wr(3'd1, 32'h05DB0007);
    wr(3'd2, 32'd0);
    edges(5);
    wr(3'd1, 32'h05DB0002);  // prescaler 6 after this edge, already above 2
    edges(3); rd(3'd2, v); chk("R7 new divisor (before)", v, 32'd0);
    edges(1); rd(3'd2, v); chk("R7 new divisor without prescaler reset", v, 32'd1);
  endtask

  task automatic t_zero_div;
    logic [31:0] v;
    wr(3'd1, 32'h05DB0000);
    wr(3'd2, 32'd0);
    edges(3); rd(3'd2, v); chk("R8 zero runs as one (before)", v, 32'd0);
    edges(1); rd(3'd2, v); chk("R8 zero runs as one (step)", v, 32'd1);
  endtask

  task automatic t_wrap;
    logic [31:0] v;
    wr(3'd1, 32'h05DB0000);
    wr(3'd2, 32'hFFFF_FFFF);
    edges(3); rd(3'd2, v); chk("R9 top value", v, 32'hFFFF_FFFF);
    edges(1); rd(3'd2, v); chk("R9 wraps to zero", v, 32'h0);
  endtask

  task automatic t_independent;
    logic [31:0] v, v0, v1;
    wr(3'd0, 32'h0);
    wr(3'd1, 32'h00030001);  // ch0 period 2, ch1 period 4
    wr(3'd2, 32'd0);
    wr(3'd3, 32'd0);
    edges(7);
    rd(3'd2, v); chk("R6 ch0 own divisor", v, 32'd2);
    rd(3'd3, v); chk("R6 ch1 own divisor (before)", v, 32'd0);
    edges(1);
    rd(3'd3, v); chk("R6 ch1 own divisor (step)", v, 32'd1);
    wr(3'd0, 32'h2);
    rd(3'd2, v0); rd(3'd3, v1);
    edges(16);
    rd(3'd3, v); chk("R6 ch1 paused alone", v, v1);
    rd(3'd2, v); chk("R6 ch0 keeps running", v, v0 + 32'd4);
    wr(3'd0, 32'h0);
  endtask

  initial begin
    #(20 * 200000);
    total++; bad++;
    $display("FAIL watchdog: got=timeout expected=completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_load_readback();
    t_reg_access();
    t_period();
    t_pause();
    t_on_the_fly();
    t_zero_div();
    t_wrap();
    t_independent();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule